// File: doc/BRIEF.md
# Dual-Channel Converter Output Formatter

This block sits behind a pair of 10-bit converter cores that sample simultaneously. It takes one sample pair per conversion, delays it by a fixed latency that depends on the operating mode, and presents it on the output pins. It also produces a complementary pair of latch clocks so that a receiving device can capture the words, and an active-low enable that releases every driven output to high impedance.

Two static configuration pins choose among four modes:
- Input-clock rate (`clk_cfg_i`): when the block runs from a fast clock, conversion happens at half the clock rate; when it runs from a slow clock, conversion happens at the clock rate.
- Bus arrangement (`one_bus_i`): each channel gets its own 10-bit bus, or the two channels take turns on one bus at twice the conversion rate.

The block raises a conversion strobe in each cycle whose closing rising edge captures a pair from the cores. The coding of the output words is selectable: unsigned offset binary, or two's complement.

Top module: `dual_adc_formatter`

## Requirements
- R1: Conversion strobe timing.
  - Behaviour: `conv_stb_o` is high in every cycle once running when `{one_bus_i,clk_cfg_i}` = 01 (slow clock). It is high in alternate cycles in the three fast-clock modes (00, 10, 11). The pair on `smp_a_i`/`smp_b_i` is captured at the rising edge that closes a cycle in which the strobe is high.
- R2: Mode 00 (fast clock, two buses).
  - Behaviour: a pair captured at edge c appears after edge c+8, with channel A on `bus_a_o` and channel B on `bus_b_o`. It is held until the next pair appears.
- R3: Mode 01 (slow clock, two buses).
  - Behaviour: a pair captured at edge c appears on the two buses after edge c+4.
- R4: Modes 10 and 11 (one bus).
  - Behaviour: the A word of a pair captured at edge c appears on `bus_a_o` after edge c+8, and the B word after edge c+9. `bus_b_o` stays 0 throughout.
- R5: Output coding.
  - `twos_i` = 0: words are unsigned, so mid-scale is 0x200, full positive 0x3FF and full negative 0x000.
  - `twos_i` = 1: bit 9 of every presented word is inverted, so 0x200 shows as 0x000, 0x3FF as 0x1FF and 0x000 as 0x200.
- R6: Latch clock in modes 00 and 10.
  - Behaviour: `lclk_o` is 0 in the cycle a new pair or A word is presented, and 1 in the following cycle.
- R7: Latch clock in mode 01.
  - Behaviour: once output is valid, `lclk_o` is the inverse of `clk`, so it rises in the middle of each word.
- R8: Latch clock in mode 11.
  - Behaviour: `lclk_o` is 1 while an A word is on `bus_a_o` and 0 while a B word is on it, so its level names the channel.
- R9: Complementary latch clock.
  - Behaviour: while enabled, `lclk_n_o` is always the inverse of `lclk_o`. Before the first word, `lclk_o` is 0.
- R10: Output enable.
  - Behaviour: with `oe_n_i` high, `bus_a_o`, `bus_b_o`, `lclk_o` and `lclk_n_o` are high impedance at once, without waiting for a clock edge. With `oe_n_i` low they are driven.
- R11: Output valid.
  - Behaviour: `valid_o` is low after reset until the first word is presented, and then stays high.
- R12: Reset state.
  - Behaviour: while `rst_n` is low, both buses read 0, `valid_o` is 0, `lclk_o` is 0 and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock (fast or slow per mode) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clk_cfg_i | input | 1 | Clock/latch-clock mode select (static) |
| one_bus_i | input | 1 | 0: two buses, 1: interleaved single bus (static) |
| twos_i | input | 1 | 1: two's complement output coding |
| oe_n_i | input | 1 | Active-low output enable for buses and latch clocks |
| smp_a_i | input | 10 | Channel A (I) sample from the core |
| smp_b_i | input | 10 | Channel B (Q) sample from the core |
| conv_stb_o | output | 1 | Conversion strobe to the cores |
| bus_a_o | output | 10 | Channel A bus, or interleaved A/B bus |
| bus_b_o | output | 10 | Channel B bus, 0 in single-bus modes |
| lclk_o | output | 1 | Latch clock |
| lclk_n_o | output | 1 | Inverted latch clock |
| valid_o | output | 1 | High once the first word has been presented |

## Verification
The bench targets the latency boundaries of each mode.
- A design that counted latency from the strobe instead of the capture edge would present each word one cycle early. So would a design that tapped the wrong pipeline stage, and in either case the bench sees a neighbouring sample.
- In the single-bus modes it checks that the B word trails the A word by exactly one cycle and never shows up on the second bus. A slot swap or an off-by-one on the B tap would put the wrong channel on the bus.

The bench also checks three further points:
- Mid-scale and full-scale codes under both codings, where an inverted wrong bit would shift every word by the wrong weight.
- The latch-clock level in each mode, which would read as the wrong channel if its polarity were swapped.
- The enable, which is released between clock edges so that a registered enable would be caught lagging.

// File: rtl/afmt_pkg.sv
package afmt_pkg;

  // Operating mode, encoded as {one_bus, clk_cfg}.
  typedef enum logic [1:0] {
    FMT_FAST_DUAL   = 2'b00,
    FMT_SLOW_DUAL   = 2'b01,
    FMT_FAST_ONEBUS = 2'b10,
    FMT_ONEBUS_2X   = 2'b11
  } fmt_e;

  function automatic fmt_e fmt_decode(input logic clk_cfg, input logic one_bus);
    return fmt_e'({one_bus, clk_cfg});
  endfunction

endpackage

// File: rtl/afmt_rst_sync.sv
module afmt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/afmt_stb_gen.sv
module afmt_stb_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_i,
  output logic stb_o
);
  logic run_q, run_d;
  logic phase_q, phase_d;

  always_comb begin
    run_d   = 1'b1;
    phase_d = run_q ? ~phase_q : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      phase_q <= phase_d;
    end
  end

  assign stb_o = run_q & (slow_i | ~phase_q);
endmodule

// File: rtl/afmt_delay.sv
module afmt_delay #(
  parameter int W     = 10,
  parameter int DEPTH = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_v,
  input  logic [W-1:0]       in_a,
  input  logic [W-1:0]       in_b,
  output logic [DEPTH-1:0]   v_o,
  output logic [DEPTH*W-1:0] a_o,
  output logic [DEPTH*W-1:0] b_o
);
  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_stage
      logic         v_q;
      logic [W-1:0] a_q, b_q;
      logic         v_d;
      logic [W-1:0] a_d, b_d;

      if (gi == 0) begin : g_head
        always_comb begin
          v_d = in_v;
          a_d = in_a;
          b_d = in_b;
        end
      end else begin : g_body
        always_comb begin
          v_d = v_o[gi-1];
          a_d = a_o[(gi-1)*W +: W];
          b_d = b_o[(gi-1)*W +: W];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          a_q <= '0;
          b_q <= '0;
        end else begin
          v_q <= v_d;
          a_q <= a_d;
          b_q <= b_d;
        end
      end

      assign v_o[gi]         = v_q;
      assign a_o[gi*W +: W]  = a_q;
      assign b_o[gi*W +: W]  = b_q;
    end
  endgenerate
endmodule

// File: rtl/afmt_outreg.sv
module afmt_outreg
  import afmt_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  fmt_e         fmt_i,
  input  logic         twos_i,
  input  logic         sv_i,
  input  logic [W-1:0] sa_i,
  input  logic [W-1:0] sb_i,
  input  logic         fv_i,
  input  logic [W-1:0] fa_i,
  input  logic [W-1:0] fb_i,
  input  logic         gv_i,
  input  logic [W-1:0] gb_i,
  output logic [W-1:0] bus_a_q,
  output logic [W-1:0] bus_b_q,
  output logic         valid_q,
  output logic         lclk_q
);
  logic [W-1:0] bus_a_d, bus_b_d;
  logic         valid_d, lclk_d;

  function automatic logic [W-1:0] recode(input logic [W-1:0] x, input logic tc);
    return tc ? {~x[W-1], x[W-2:0]} : x;
  endfunction

  always_comb begin
    bus_a_d = bus_a_q;
    bus_b_d = bus_b_q;
    valid_d = valid_q;
    lclk_d  = lclk_q;
    unique case (fmt_i)
      FMT_FAST_DUAL: begin
        if (fv_i) begin
          bus_a_d = recode(fa_i, twos_i);
          bus_b_d = recode(fb_i, twos_i);
          valid_d = 1'b1;
          lclk_d  = 1'b0;
        end else begin
          lclk_d  = valid_q;
        end
      end
      FMT_SLOW_DUAL: begin
        lclk_d = 1'b0;
        if (sv_i) begin
          bus_a_d = recode(sa_i, twos_i);
          bus_b_d = recode(sb_i, twos_i);
          valid_d = 1'b1;
        end
      end
      FMT_FAST_ONEBUS, FMT_ONEBUS_2X: begin
        bus_b_d = '0;
        if (fv_i) begin
          bus_a_d = recode(fa_i, twos_i);
          valid_d = 1'b1;
          lclk_d  = (fmt_i == FMT_ONEBUS_2X);
        end else if (gv_i) begin
          bus_a_d = recode(gb_i, twos_i);
          lclk_d  = (fmt_i == FMT_FAST_ONEBUS);
        end
      end
      default: begin
        bus_a_d = bus_a_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_a_q <= '0;
      bus_b_q <= '0;
      valid_q <= 1'b0;
      lclk_q  <= 1'b0;
    end else begin
      bus_a_q <= bus_a_d;
      bus_b_q <= bus_b_d;
      valid_q <= valid_d;
      lclk_q  <= lclk_d;
    end
  end
endmodule

// File: rtl/dual_adc_formatter.sv
module dual_adc_formatter
  import afmt_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int LAT_FAST    = 8,
  parameter int LAT_SLOW    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_cfg_i,
  input  logic              one_bus_i,
  input  logic              twos_i,
  input  logic              oe_n_i,
  input  logic [DATA_W-1:0] smp_a_i,
  input  logic [DATA_W-1:0] smp_b_i,
  output logic              conv_stb_o,
  output logic [DATA_W-1:0] bus_a_o,
  output logic [DATA_W-1:0] bus_b_o,
  output logic              lclk_o,
  output logic              lclk_n_o,
  output logic              valid_o
);
  localparam int DEPTH = LAT_FAST + 1;
  localparam int TAP_S = LAT_SLOW - 1;
  localparam int TAP_F = LAT_FAST - 1;
  localparam int TAP_G = LAT_FAST;

  fmt_e fmt;
  logic slow_mode;
  logic rst_sync_n;
  logic stb;

  logic [DEPTH-1:0]        pv;
  logic [DEPTH*DATA_W-1:0] pa, pb;

  logic [DATA_W-1:0] bus_a_q, bus_b_q;
  logic              valid_q, lclk_q, lclk_int;

  assign fmt       = fmt_decode(clk_cfg_i, one_bus_i);
  assign slow_mode = (fmt == FMT_SLOW_DUAL);

  afmt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  afmt_stb_gen u_stb (
    .clk(clk), .rst_n(rst_sync_n), .slow_i(slow_mode), .stb_o(stb)
  );

  afmt_delay #(.W(DATA_W), .DEPTH(DEPTH)) u_dly (
    .clk(clk), .rst_n(rst_sync_n),
    .in_v(stb), .in_a(smp_a_i), .in_b(smp_b_i),
    .v_o(pv), .a_o(pa), .b_o(pb)
  );

  afmt_outreg #(.W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_sync_n),
    .fmt_i(fmt), .twos_i(twos_i),
    .sv_i(pv[TAP_S]), .sa_i(pa[TAP_S*DATA_W +: DATA_W]), .sb_i(pb[TAP_S*DATA_W +: DATA_W]),
    .fv_i(pv[TAP_F]), .fa_i(pa[TAP_F*DATA_W +: DATA_W]), .fb_i(pb[TAP_F*DATA_W +: DATA_W]),
    .gv_i(pv[TAP_G]), .gb_i(pb[TAP_G*DATA_W +: DATA_W]),
    .bus_a_q(bus_a_q), .bus_b_q(bus_b_q), .valid_q(valid_q), .lclk_q(lclk_q)
  );

  // Input-rate latch clock in slow mode, registered level otherwise.
  assign lclk_int = slow_mode ? (valid_q & ~clk) : lclk_q;

  assign conv_stb_o = stb;
  assign valid_o    = valid_q;
  assign bus_a_o    = oe_n_i ? {DATA_W{1'bz}} : bus_a_q;
  assign bus_b_o    = oe_n_i ? {DATA_W{1'bz}} : bus_b_q;
  assign lclk_o     = oe_n_i ? 1'bz : lclk_int;
  assign lclk_n_o   = oe_n_i ? 1'bz : ~lclk_int;
endmodule

// File: rtl/afmt_checks.sv
module afmt_checks #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              clk_cfg_i,
  input logic              one_bus_i,
  input logic              stb,
  input logic              valid_q,
  input logic              lclk_q,
  input logic [DATA_W-1:0] bus_b_q
);
  // R1: fast-clock modes never strobe in two consecutive cycles
  assert_stb_alternates_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stb && !(clk_cfg_i && !one_bus_i)) |=> !stb);

  // R1: slow-clock mode strobes every cycle once started
  assert_stb_every_cycle_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stb && clk_cfg_i && !one_bus_i) |=> stb);

  // R11: valid never drops without reset
  assert_valid_sticky_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid_q |=> valid_q);

  // R4: second bus register stays zero in single-bus modes
  assert_busb_zero_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    one_bus_i |-> (bus_b_q == '0));

  // R8: in the single-bus double-rate mode the latch clock level flips every word
  assert_lclk_flips_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_q && one_bus_i && clk_cfg_i) |=> (lclk_q != $past(lclk_q)));
endmodule

bind dual_adc_formatter afmt_checks #(.DATA_W(DATA_W)) u_afmt_checks (
  .clk(clk), .rst_sync_n(rst_sync_n), .clk_cfg_i(clk_cfg_i), .one_bus_i(one_bus_i),
  .stb(stb), .valid_q(valid_q), .lclk_q(lclk_q), .bus_b_q(bus_b_q)
);

// File: tb/dual_adc_formatter_bench.sv
`timescale 1ns/1ps
module dual_adc_formatter_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       clk_cfg, one_bus, twos, oe_n;
  logic [9:0] smp_a, smp_b;
  logic       conv_stb, valid;
  tri1  [9:0] w_bus_a, w_bus_b;
  tri1        w_lclk, w_lclk_n;

  int n_checks = 0;
  int n_fail   = 0;
  int ecnt     = 0;
  int ncap     = 0;
  int cap_e [0:255];
  logic [9:0] cap_a [0:255];
  logic [9:0] cap_b [0:255];
  bit prev_stb;

  always #10 clk = ~clk;
  always @(posedge clk) ecnt = ecnt + 1;

  dual_adc_formatter u_dual_adc_formatter (
    .clk(clk), .rst_n(rst_n), .clk_cfg_i(clk_cfg), .one_bus_i(one_bus),
    .twos_i(twos), .oe_n_i(oe_n), .smp_a_i(smp_a), .smp_b_i(smp_b),
    .conv_stb_o(conv_stb), .bus_a_o(w_bus_a), .bus_b_o(w_bus_b),
    .lclk_o(w_lclk), .lclk_n_o(w_lclk_n), .valid_o(valid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (edge %0d)", tag, act, exp, ecnt);
    end
  endtask

  function automatic logic [9:0] code(input logic [9:0] v);
    return twos ? (v ^ 10'h200) : v;
  endfunction

  function automatic logic [9:0] pat(input int k, input int salt);
    if (k == 0) return 10'h200;
    if (k == 1) return 10'h3FF;
    if (k == 2) return 10'h000;
    return 10'((k * 37 + salt * 101) & 10'h3FF);
  endfunction

  task automatic check_now();
    int L; int j; bit vld; logic [9:0] ea, eb; bit el;
    string tb, tl;
    L  = (clk_cfg && !one_bus) ? 4 : 8;
    j  = -1;
    for (int i = 0; i < ncap; i++) if (cap_e[i] + L <= ecnt) j = i;
    vld = (j >= 0); ea = '0; eb = '0; el = 1'b0;
    tb = !one_bus ? (clk_cfg ? "R3" : "R2") : "R4";
    if (twos) tb = {tb, "/R5"};
    tl = (clk_cfg && !one_bus) ? "R7" : ((clk_cfg && one_bus) ? "R8" : "R6");
    if (vld && !one_bus) begin
      ea = code(cap_a[j]); eb = code(cap_b[j]);
      el = clk_cfg ? 1'b1 : ((ecnt - cap_e[j] - 8) == 1);
    end else if (vld) begin
      if (cap_e[j] + 8 == ecnt) begin ea = code(cap_a[j]); el = clk_cfg; end
      else                      begin ea = code(cap_b[j]); el = !clk_cfg; end
    end
    chk("R11 valid", int'(valid), int'(vld));
    if (oe_n) begin
      chk("R10 bus_a hi-z", int'(w_bus_a), 10'h3FF);
      chk("R10 bus_b hi-z", int'(w_bus_b), 10'h3FF);
      chk("R10 lclk hi-z", int'(w_lclk), 1);
      chk("R10 lclk_n hi-z", int'(w_lclk_n), 1);
    end else begin
      chk({tb, " bus_a"}, int'(w_bus_a), int'(ea));
      chk({tb, " bus_b"}, int'(w_bus_b), int'(eb));
      chk({tl, " lclk"}, int'(w_lclk), int'(el));
      chk("R9 lclk_n", int'(w_lclk_n), int'(!el));
    end
  endtask

  task automatic run(input int n);
    for (int c = 0; c < n; c++) begin
      logic [9:0] na, nb;
      @(negedge clk); #1;
      check_now();
      if (clk_cfg && !one_bus) begin
        if (prev_stb) chk("R1 stb every cycle", int'(conv_stb), 1);
      end else if (prev_stb) begin
        chk("R1 stb alternate", int'(conv_stb), 0);
      end
      prev_stb = conv_stb;
      na = pat(ncap, 1); nb = pat(ncap + 5, 2);
      smp_a = na; smp_b = nb;
      if (conv_stb) begin
        cap_e[ncap] = ecnt + 1; cap_a[ncap] = na; cap_b[ncap] = nb;
        ncap++;
      end
    end
  endtask

  task automatic do_reset(input bit cfg, input bit one, input bit tw);
    @(negedge clk);
    rst_n = 1'b0; clk_cfg = cfg; one_bus = one; twos = tw; oe_n = 1'b0;
    ncap = 0; prev_stb = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R12 reset bus_a", int'(w_bus_a), 0);
    chk("R12 reset bus_b", int'(w_bus_b), 0);
    chk("R12 reset valid", int'(valid), 0);
    chk("R12 reset lclk", int'(w_lclk), 0);
    chk("R12 reset stb", int'(conv_stb), 0);
    rst_n = 1'b1;
  endtask

  task automatic scen_fast_dual(input bit tw);   do_reset(0, 0, tw); run(60); endtask
  task automatic scen_slow_dual(input bit tw);   do_reset(1, 0, tw); run(40); endtask
  task automatic scen_onebus_rate(input bit tw); do_reset(0, 1, tw); run(60); endtask
  task automatic scen_onebus_2x(input bit tw);   do_reset(1, 1, tw); run(60); endtask

  task automatic scen_enable();
    do_reset(1, 0, 0);
    run(20);
    @(negedge clk); #3;
    oe_n = 1'b1; #1;
    check_now();                 // R10: released without a clock edge
    run(6);
    @(negedge clk); #3;
    oe_n = 1'b0; #1;
    check_now();                 // R10: driven again without a clock edge
    run(10);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clk_cfg = 1'b0; one_bus = 1'b0; twos = 1'b0; oe_n = 1'b0;
    smp_a = '0; smp_b = '0;
    scen_fast_dual(0);
    scen_fast_dual(1);
    scen_slow_dual(0);
    scen_slow_dual(1);
    scen_onebus_rate(0);
    scen_onebus_2x(0);
    scen_onebus_2x(1);
    scen_enable();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule